// File: doc/BRIEF.md
# Multi-Bank Gather/Scatter Scratchpad

This block is a lane-parallel scratchpad memory split into `LANES` independent banks. On each operation every lane offers a word address, a write word, a per-byte write enable and a participation bit. One shared store flag makes the whole operation either a scatter (write) or a gather (read). The word address picks a bank through its low bits and a row inside that bank through its upper bits. When participating lanes fall into different banks, the operation takes a single access cycle. When several lanes share a bank, their accesses to that bank are spread over consecutive cycles.

A core requests an operation by raising start while the block shows ready. The block then goes busy and issues accesses. In each cycle the lowest-numbered pending lane takes each bank, and a lane leaves the pending set once it has been served. When no lane remains pending, the block pulses valid for one cycle with ready high again. From that pulse until the next accepted request, the per-lane read words are final and stay stable.

Top module: `spm_gather_scatter`

## Requirements
- R1: After reset, ready_o is 1, valid_o is 0 and every lane of rdata_o is zero.
- R2: A request is taken on a rising clock edge where start_i and ready_o are both 1, and ready_o is 0 in the next cycle. A start_i raised while ready_o is 0 is ignored: it writes nothing and does not change the duration of the running operation.
- R3: The bank of a lane is its address modulo LANES, which is addr bits [1:0] for 4 lanes. If every participating lane is in a different bank, valid_o rises one clock after the accepting edge.
- R4: If at most N participating lanes share any one bank, valid_o rises N clocks after the accepting edge. Same-address lanes count as a conflict.
- R5: On a gather, each participating lane returns the word stored at its address.
- R6: On a scatter, byte k of a lane's word (bits 8k+7..8k) is written only when bit k of that lane's byte enable is 1. All other bytes keep their old contents.
- R7: A lane whose participation bit is 0 is never issued and returns zero. An operation with no participating lanes completes one clock after acceptance.
- R8: When several lanes of one scatter write the same address, the highest-numbered of them decides every byte it enables.
- R9: valid_o is a single-cycle pulse that occurs only while ready_o is 1. rdata_o holds its value until the next request is accepted.
- R10: A scatter returns zero on every lane of rdata_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation |
| store_i | input | 1 | 1 selects scatter, 0 selects gather |
| lane_en_i | input | LANES | Per-lane participation bit |
| addr_i | input | LANES x ADDR_W | Per-lane word address |
| wdata_i | input | LANES x DATA_W | Per-lane write word |
| be_i | input | LANES x DATA_W/8 | Per-lane byte write enable |
| ready_o | output | 1 | Block can take a request |
| valid_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | LANES x DATA_W | Per-lane read word |

## Verification
The hardest case to reach from the ports is a start request raised in the middle of a multi-cycle conflict. If the core holds start too long, the block accepts the request when it becomes free. The bench starts a four-way same-bank gather and raises a conflicting scatter only during the busy cycles. It drops start one cycle before completion, then reads the target word back to show that nothing was written. Ordered writes are also hard to reach: several lanes scatter to one address with mixed byte enables, and a later gather shows which lane decided each byte.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic {
    ST_READY = 1'b0,
    ST_BUSY  = 1'b1
  } spm_state_e;
endpackage

// File: rtl/spm_bank_arb.sv
module spm_bank_arb #(
  parameter int LANES  = 4,
  parameter int BANK_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]             pend_i,
  input  logic [LANES-1:0][BANK_W-1:0] bank_i,
  output logic [LANES-1:0]             grant_o,
  output logic [LANES-1:0]             hit_o,
  output logic [LANES-1:0][BANK_W-1:0] lane_o
);
  // one arbiter per bank, lowest pending lane wins
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    always_comb begin
      hit_o[b]  = 1'b0;
      lane_o[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pend_i[l] && bank_i[l] == BANK_W'(b)) begin
          hit_o[b]  = 1'b1;
          lane_o[b] = BANK_W'(l);
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      grant_o[l] = pend_i[l] && hit_o[bank_i[l]] && (lane_o[bank_i[l]] == BANK_W'(l));
    end
  end
endmodule

// File: rtl/spm_bank.sv
module spm_bank #(
  parameter int ROW_W  = 6,
  parameter int DATA_W = 32,
  localparam int ROWS  = 1 << ROW_W,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BYTES-1:0]  be_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < BYTES; k++) begin
        if (be_i[k]) mem_q[row_i][8*k +: 8] <= wdata_i[8*k +: 8];
      end
    end
  end

  assign rdata_o = mem_q[row_i];
endmodule

// File: rtl/spm_gather_scatter.sv
module spm_gather_scatter
  import spm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BYTES  = DATA_W / 8,
  localparam int BANK_W = $clog2(LANES),
  localparam int ROW_W  = ADDR_W - BANK_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         store_i,
  input  logic [LANES-1:0]             lane_en_i,
  input  logic [LANES-1:0][ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0][DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0][BYTES-1:0]  be_i,
  output logic                         ready_o,
  output logic                         valid_o,
  output logic [LANES-1:0][DATA_W-1:0] rdata_o
);
  spm_state_e                   state_q;
  logic                         store_q, valid_q;
  logic [LANES-1:0]             pend_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][DATA_W-1:0] wdata_q, rdata_q;
  logic [LANES-1:0][BYTES-1:0]  be_q;

  logic [LANES-1:0][BANK_W-1:0] bank_sel;
  logic [LANES-1:0][ROW_W-1:0]  row_sel;
  logic [LANES-1:0]             grant, hit;
  logic [LANES-1:0][BANK_W-1:0] win_lane;
  logic [LANES-1:0][DATA_W-1:0] bank_rd;
  logic [LANES-1:0]             pend_nxt;
  logic                         accept;

  assign accept   = start_i && (state_q == ST_READY);
  assign pend_nxt = pend_q & ~grant;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      bank_sel[l] = addr_q[l][BANK_W-1:0];
      row_sel[l]  = addr_q[l][ADDR_W-1:BANK_W];
    end
  end

  spm_bank_arb #(.LANES(LANES), .BANK_W(BANK_W)) u_arb (
    .pend_i  (pend_q),
    .bank_i  (bank_sel),
    .grant_o (grant),
    .hit_o   (hit),
    .lane_o  (win_lane)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    spm_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk_i   (clk_i),
      .we_i    (hit[b] && store_q && state_q == ST_BUSY),
      .row_i   (row_sel[win_lane[b]]),
      .wdata_i (wdata_q[win_lane[b]]),
      .be_i    (be_q[win_lane[b]]),
      .rdata_o (bank_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;
      store_q <= 1'b0;
      valid_q <= 1'b0;
      pend_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        state_q <= ST_BUSY;
        store_q <= store_i;
        pend_q  <= lane_en_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        be_q    <= be_i;
        rdata_q <= '0;
      end else if (state_q == ST_BUSY) begin
        pend_q <= pend_nxt;
        for (int l = 0; l < LANES; l++) begin
          if (grant[l] && !store_q) rdata_q[l] <= bank_rd[bank_sel[l]];
        end
        if (pend_nxt == '0) begin
          state_q <= ST_READY;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign ready_o = (state_q == ST_READY);
  assign valid_o = valid_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/spm_gs_chk.sv
module spm_gs_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         start_i,
  input logic                         store_i,
  input logic [LANES-1:0]             lane_en_i,
  input logic                         ready_o,
  input logic                         valid_o,
  input logic [LANES-1:0][DATA_W-1:0] rdata_o
);
  localparam int CNT_W = $clog2(LANES + 2) + 1;

  logic [LANES-1:0] en_q;
  logic             st_q;
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      st_q     <= 1'b0;
      busy_cnt <= '0;
    end else if (ready_o && start_i) begin
      en_q     <= lane_en_i;
      st_q     <= store_i;
      busy_cnt <= '0;
    end else if (!ready_o && busy_cnt != '1) begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |=> !ready_o);
  assert_fall_only_on_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(start_i));
  assert_bounded_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= CNT_W'(LANES));
  assert_valid_with_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ready_o);
  assert_valid_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_scatter_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && st_q |-> rdata_o == '0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assert_idle_lane_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && !en_q[l] |-> rdata_o[l] == '0);
  end
endmodule

bind spm_gather_scatter spm_gs_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .store_i   (store_i),
  .lane_en_i (lane_en_i),
  .ready_o   (ready_o),
  .valid_o   (valid_o),
  .rdata_o   (rdata_o)
);

// File: tb/sim_spm_gather_scatter.sv
module sim_spm_gather_scatter;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int DW = 32;
  localparam int AW = 8;

  typedef struct packed {
    logic              st;
    logic [3:0]        en;
    logic [3:0][7:0]   a;
    logic [3:0][31:0]  d;
    logic [3:0][3:0]   be;
    logic [3:0]        cyc;
  } vec_t;

  // cyc = expected clocks from accept to valid
  localparam vec_t VEC [12] = '{
    '{1'b0, 4'hF, {8'h43, 8'h32, 8'h21, 8'h10}, '0, '0, 4'd1},                // R3 R5
    '{1'b0, 4'hF, {8'h10, 8'h0C, 8'h08, 8'h04}, '0, '0, 4'd4},                // R4
    '{1'b0, 4'hF, {8'h06, 8'h02, 8'h05, 8'h01}, '0, '0, 4'd2},                // R4
    '{1'b0, 4'h5, {8'h0C, 8'h08, 8'h04, 8'h00}, '0, '0, 4'd2},                // R7
    '{1'b1, 4'hF, {8'h53, 8'h42, 8'h31, 8'h20},
      {32'hDDDD_0003, 32'hCC00_0002, 32'hBBBB_BB01, 32'hAAAA_AA00},
      {4'b1111, 4'b1000, 4'b0110, 4'b0001}, 4'd1},                            // R6 R10
    '{1'b0, 4'hF, {8'h53, 8'h42, 8'h31, 8'h20}, '0, '0, 4'd1},                // R6
    '{1'b1, 4'hF, {8'h70, 8'h70, 8'h70, 8'h70},
      {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_0000},
      {4'hF, 4'hF, 4'hF, 4'hF}, 4'd4},                                        // R8
    '{1'b0, 4'hF, {8'h70, 8'h70, 8'h70, 8'h70}, '0, '0, 4'd4},                // R8
    '{1'b1, 4'h0, {8'h83, 8'h82, 8'h81, 8'h80}, {4{32'hFFFF_FFFF}},
      {4{4'hF}}, 4'd1},                                                       // R7
    '{1'b0, 4'hF, {8'h83, 8'h82, 8'h81, 8'h80}, '0, '0, 4'd1},                // R7
    '{1'b1, 4'h6, {8'h90, 8'h90, 8'h90, 8'h90},
      {32'h0, 32'h0000_BEEF, 32'h1234_5678, 32'h0},
      {4'b0000, 4'b0011, 4'b1111, 4'b0000}, 4'd2},                            // R8 R6
    '{1'b0, 4'h1, {8'h00, 8'h00, 8'h00, 8'h90}, '0, '0, 4'd1}                 // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic store = 1'b0;
  logic [L-1:0] lane_en = '0;
  logic [L-1:0][AW-1:0] addr = '0;
  logic [L-1:0][DW-1:0] wdata = '0;
  logic [L-1:0][DW/8-1:0] be = '0;
  logic ready, valid;
  logic [L-1:0][DW-1:0] rdata;

  logic [DW-1:0] ref_mem [256];
  int total = 0;
  int bad = 0;
  int ticks = 0;
  bit hung = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_gather_scatter #(.LANES(L), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .lane_en_i(lane_en), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .ready_o(ready), .valid_o(valid), .rdata_o(rdata)
  );

  always @(posedge clk) begin
    ticks <= ticks + 1;
    if (ticks > 150000) hung <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int a);
    return {8'(a), 8'(a) ^ 8'h5A, ~8'(a), 8'(a + 1)};
  endfunction

  // issue one request, return clocks from accepting edge until valid
  task automatic run_op(input vec_t v, output int cyc);
    @(negedge clk);
    start = 1'b1; store = v.st; lane_en = v.en; addr = v.a; wdata = v.d; be = v.be;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!valid && cyc < 40 && !hung) begin
      @(negedge clk);
      cyc++;
    end
    if (v.st) begin
      for (int l = 0; l < L; l++)
        if (v.en[l])
          for (int k = 0; k < 4; k++)
            if (v.be[l][k]) ref_mem[v.a[l]][8*k +: 8] = v.d[l][8*k +: 8];
    end
  endtask

  task automatic check_result(input vec_t v, input string req);
    logic [31:0] exp;
    for (int l = 0; l < L; l++) begin
      exp = (!v.st && v.en[l]) ? ref_mem[v.a[l]] : 32'h0;
      chk(rdata[l] === exp, req, rdata[l], exp);
    end
  endtask

  initial begin
    int cyc;
    vec_t v;
    logic [31:0] hold0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state
    chk(ready === 1'b1, "R1 ready", 32'(ready), 32'h1);
    chk(valid === 1'b0, "R1 valid", 32'(valid), 32'h0);
    chk(rdata === '0, "R1 rdata", rdata[0], 32'h0);
    rst_n = 1'b1;

    // preload: four consecutive words per op hit four distinct banks (R3, R10)
    for (int i = 0; i < 64; i++) begin
      v = '0;
      v.st = 1'b1; v.en = 4'hF;
      for (int l = 0; l < L; l++) begin
        v.a[l]  = 8'(4 * i + l);
        v.d[l]  = init_word(4 * i + l);
        v.be[l] = 4'hF;
      end
      run_op(v, cyc);
      if (i < 2 || i == 63) begin
        chk(cyc == 1, "R3 preload cycles", 32'(cyc), 32'd1);
        chk(rdata === '0, "R10 preload rdata", rdata[0], 32'h0);
      end
    end

    // table walk
    for (int i = 0; i < 12; i++) begin
      run_op(VEC[i], cyc);
      chk(cyc == int'(VEC[i].cyc), $sformatf("R4 cycles vec%0d", i), 32'(cyc), 32'(VEC[i].cyc));
      check_result(VEC[i], $sformatf("R5 data vec%0d", i));
    end

    // R9: valid is a pulse, rdata holds afterwards
    v = VEC[0];
    run_op(v, cyc);
    hold0 = rdata[0];
    chk(ready === 1'b1, "R9 ready with valid", 32'(ready), 32'h1);
    @(negedge clk);
    chk(valid === 1'b0, "R9 valid pulse", 32'(valid), 32'h0);
    repeat (3) @(negedge clk);
    chk(rdata[0] === hold0, "R9 rdata hold", rdata[0], hold0);

    // R2: start during busy is ignored
    @(negedge clk);
    start = 1'b1; store = 1'b0; lane_en = 4'hF;
    addr = {8'h1C, 8'h18, 8'h14, 8'h10};
    @(posedge clk);
    @(negedge clk);
    chk(ready === 1'b0, "R2 busy after accept", 32'(ready), 32'h0);
    store = 1'b1; wdata = {4{32'hDEAD_BEEF}}; be = {4{4'hF}};
    addr = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    cyc = 0;
    while (!valid && cyc < 40 && !hung) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) start = 1'b0;
    end
    start = 1'b0;
    chk(cyc == 4, "R2 cycles unchanged", 32'(cyc), 32'd4);
    chk(rdata[3] === ref_mem[8'h1C], "R2 gather data", rdata[3], ref_mem[8'h1C]);
    @(negedge clk);
    chk(ready === 1'b1 && valid === 1'b0, "R2 stays idle", 32'(ready), 32'h1);
    v = '0; v.en = 4'hF; v.a = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    run_op(v, cyc);
    check_result(v, "R2 no write while busy");

    if (hung) chk(1'b0, "watchdog", 32'(ticks), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 180000);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=done", ticks);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule